// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Receive Interrupt Policy

This block turns an asynchronous serial line into parallel characters. A baud generator gives it a sampling enable (`bitTick`). The block counts one, sixteen, thirty-two or sixty-four of these ticks per bit period. Packed control bytes set the character length, the parity, the stop-bit length and the sampling multiplier. At oversampled rates the start bit is checked again at its half-bit point, so a short glitch cannot begin a character. Each data bit is then sampled at its centre.

A received character goes into a single holding register and raises a ready flag. Three sticky error flags record special conditions: a missing stop bit, a character lost because the previous one was never read, and a parity mismatch. A receive interrupt request comes from these flags and the ready state. A two-bit policy field selects it: off, first character only (re-armed by a strobe), every character, or special conditions only. A separate enable bit decides whether a parity mismatch counts as a special condition.

Top module: `async_rx_irq`

## Requirements
- R1: After reset, `rxData`, `rxReady`, `errStatus` and `rxIrq` are all zero.
- R2: `rxCtrl[7:6]` selects the character length: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8. Bits arrive LSB first and are right-justified in `rxData`, with the unused high bits zero. `rxReady` rises when the first stop bit is sampled.
- R3: `modeCtrl[7:6]` selects 1, 16, 32 or 64 ticks per bit (codes 00, 01, 10, 11). Above ×1, the start bit is confirmed low half a bit after it is first seen, and each later bit is sampled one full bit period after the previous sample.
- R4: At ×16 or higher, a low pulse that has ended by the half-bit check is discarded and produces no character.
- R5: `modeCtrl[0]` enables a parity bit after the data, and `modeCtrl[1]` set means even parity, clear means odd. A mismatch sets `errStatus[4]`.
- R6: A low first stop bit sets `errStatus[6]`. `modeCtrl[3:2]` = 10 or 11 adds a dead time of half a bit or one bit after the stop sample (one tick at ×1). Frames sent back to back with the programmed stop length are all received.
- R7: A character that completes while `rxReady` is still set sets `errStatus[5]` and replaces the held data.
- R8: Error flags stay set through later good characters until an `errClear` pulse clears them.
- R9: A `dataRead` pulse clears `rxReady`.
- R10: `intCtrl[4:3]` = 00 keeps `rxIrq` low. With 11, `rxIrq` follows special conditions only and ignores good characters.
- R11: With `intCtrl[4:3]` = 10, `rxIrq` is high while a character is ready or a special condition is flagged.
- R12: With `intCtrl[4:3]` = 01, only the first character after reset or after a `rearmFirst` pulse raises `rxIrq`, which stays high until `dataRead`.
- R13: A parity error raises `rxIrq` only when `intCtrl[2]` is set. The `errStatus[4]` flag is recorded either way.
- R14: With `rxCtrl[0]` clear, the receiver ignores the line and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial input, idle high |
| bitTick | input | 1 | Sampling enable from the baud generator |
| rxCtrl | input | 8 | [7:6] length code, [0] receiver enable |
| modeCtrl | input | 8 | [7:6] multiplier, [3:2] stop code, [1] even parity, [0] parity enable |
| intCtrl | input | 8 | [4:3] interrupt policy, [2] parity error is special |
| dataRead | input | 1 | Pulse: character consumed |
| errClear | input | 1 | Pulse: clear error flags |
| rearmFirst | input | 1 | Pulse: re-arm first-character interrupt |
| rxData | output | 8 | Last received character |
| rxReady | output | 1 | Character available |
| errStatus | output | 8 | [6] framing, [5] overrun, [4] parity, others zero |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The block has no build parameters, so the bench uses the defaults: an 8-bit holding register and a 64-tick maximum multiplier. This keeps the full control space small enough to sweep. The bench receives every length code with no, even and odd parity at ×16, using several data patterns. It runs single frames at ×1, ×32 and ×64. Each interrupt policy is exercised with good, framing-error and parity-error characters. The bench computes expected data, masks and parity bits arithmetically from the requirements.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_MULT = 64;
  localparam int CNT_W    = $clog2(MAX_MULT) + 1;
  localparam int IDX_W    = $clog2(DATA_W);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_GUARD
  } rxState_e;

  typedef struct packed {
    logic             frameBegin;
    logic             dataBit;
    logic             parBit;
    logic             stopBit;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobe_t;

  // Index of the last data bit for a length code (5,7,6,8 bits).
  function automatic logic [IDX_W-1:0] lastIdxOf(input logic [1:0] code);
    case (code)
      2'b00:   return IDX_W'(4);
      2'b01:   return IDX_W'(6);
      2'b10:   return IDX_W'(5);
      default: return IDX_W'(7);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] multOf(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(16);
      2'b10:   return CNT_W'(32);
      default: return CNT_W'(MAX_MULT);
    endcase
  endfunction

  // Dead time after the stop sample, in ticks.
  function automatic logic [CNT_W-1:0] guardOf(input logic [1:0] stopCode,
                                               input logic [CNT_W-1:0] mult);
    case (stopCode)
      2'b10:   return (mult == CNT_W'(1)) ? CNT_W'(1) : (mult >> 1);
      2'b11:   return mult;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       bitTick,
  input  logic       rxEnable,
  input  logic [1:0] sizeCode,
  input  logic [1:0] multCode,
  input  logic [1:0] stopCode,
  input  logic       parEnable,
  output rxStrobe_t  strobe
);
  rxState_e         state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt, cntInc, mult, half, guard;
  logic [IDX_W-1:0] idx, nextIdx, lastIdx;

  always_comb begin
    mult      = multOf(multCode);
    half      = mult >> 1;
    guard     = guardOf(stopCode, mult);
    lastIdx   = lastIdxOf(sizeCode);
    cntInc    = cnt + 1'b1;
    nextState = state;
    nextCnt   = cnt;
    nextIdx   = idx;
    strobe    = '0;
    strobe.bitIdx = idx;
    if (!rxEnable) begin
      nextState = S_IDLE;
      nextCnt   = '0;
      nextIdx   = '0;
    end else if (bitTick) begin
      case (state)
        S_IDLE: if (!rxLine) begin
          nextCnt = '0;
          nextIdx = '0;
          if (mult == CNT_W'(1)) begin
            nextState = S_DATA;
            strobe.frameBegin = 1'b1;
          end else begin
            nextState = S_START;
          end
        end
        S_START: if (cntInc == half) begin
          nextCnt = '0;
          if (!rxLine) begin
            nextState = S_DATA;
            strobe.frameBegin = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end else nextCnt = cntInc;
        S_DATA: if (cntInc == mult) begin
          nextCnt = '0;
          strobe.dataBit = 1'b1;
          if (idx == lastIdx) nextState = parEnable ? S_PAR : S_STOP;
          else nextIdx = idx + 1'b1;
        end else nextCnt = cntInc;
        S_PAR: if (cntInc == mult) begin
          nextCnt = '0;
          strobe.parBit = 1'b1;
          nextState = S_STOP;
        end else nextCnt = cntInc;
        S_STOP: if (cntInc == mult) begin
          nextCnt = '0;
          strobe.stopBit = 1'b1;
          nextState = (guard == '0) ? S_IDLE : S_GUARD;
        end else nextCnt = cntInc;
        S_GUARD: if (cntInc == guard) begin
          nextCnt = '0;
          nextState = S_IDLE;
        end else nextCnt = cntInc;
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      idx   <= nextIdx;
    end
  end

  // R3: at most one sampling action per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.frameBegin, strobe.dataBit, strobe.parBit, strobe.stopBit}));

  // R14: a disabled receiver is parked in idle
  p_idle_when_off_r14: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == S_IDLE));
endmodule

// File: rtl/rxa_dpath.sv
module rxa_dpath
  import rxa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic              parEven,
  input  logic [1:0]        irqMode,
  input  logic              parSpecial,
  input  logic              dataRead,
  input  logic              errClear,
  input  logic              rearmFirst,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              errFe,
  output logic              errOv,
  output logic              errPe,
  output logic              rxIrq
);
  logic [DATA_W-1:0] shiftReg;
  logic parBad, armed, firstHit, special;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBad   <= 1'b0;
    end else if (strobe.frameBegin) begin
      shiftReg <= '0;
      parBad   <= 1'b0;
    end else if (strobe.dataBit) begin
      shiftReg[strobe.bitIdx] <= rxLine;
    end else if (strobe.parBit) begin
      parBad <= (^shiftReg) ^ rxLine ^ ~parEven;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxReady  <= 1'b0;
      errFe    <= 1'b0;
      errOv    <= 1'b0;
      errPe    <= 1'b0;
      armed    <= 1'b1;
      firstHit <= 1'b0;
    end else begin
      errFe <= (errFe & ~errClear) | (strobe.stopBit & ~rxLine);
      errOv <= (errOv & ~errClear) | (strobe.stopBit & rxReady & ~dataRead);
      errPe <= (errPe & ~errClear) | (strobe.stopBit & parBad);
      if (strobe.stopBit) begin
        rxData  <= shiftReg;
        rxReady <= 1'b1;
      end else if (dataRead) begin
        rxReady <= 1'b0;
      end
      if (strobe.stopBit && armed && irqMode == 2'b01) begin
        firstHit <= 1'b1;
        armed    <= 1'b0;
      end else begin
        if (dataRead)   firstHit <= 1'b0;
        if (rearmFirst) armed    <= 1'b1;
      end
    end
  end

  always_comb begin
    special = errFe | errOv | (errPe & parSpecial);
    case (irqMode)
      2'b01:   rxIrq = special | firstHit;
      2'b10:   rxIrq = special | rxReady;
      2'b11:   rxIrq = special;
      default: rxIrq = 1'b0;
    endcase
  end

  // R2: a sampled stop bit always leaves a character ready
  p_ready_on_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopBit |=> rxReady);

  // R7: completion over an unread character records an overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stopBit && rxReady && !dataRead) |=> errOv);

  // R8: framing flag only drops after a clear request
  p_fe_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errFe) |-> $past(errClear));

  // R9: a read with no completing character empties the holder
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !strobe.stopBit) |=> !rxReady);

  // R10: policy 00 never requests
  p_no_irq_mode0_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqMode == 2'b00) |-> !rxIrq);
endmodule

// File: rtl/async_rx_irq.sv
module async_rx_irq
  import rxa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              bitTick,
  input  logic [7:0]        rxCtrl,
  input  logic [7:0]        modeCtrl,
  input  logic [7:0]        intCtrl,
  input  logic              dataRead,
  input  logic              errClear,
  input  logic              rearmFirst,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic [7:0]        errStatus,
  output logic              rxIrq
);
  rxStrobe_t strobe;
  logic errFe, errOv, errPe;
  logic unusedCfg;

  assign unusedCfg = ^{rxCtrl[5:1], modeCtrl[5:4], intCtrl[7:5], intCtrl[1:0]};

  rxa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .bitTick   (bitTick),
    .rxEnable  (rxCtrl[0]),
    .sizeCode  (rxCtrl[7:6]),
    .multCode  (modeCtrl[7:6]),
    .stopCode  (modeCtrl[3:2]),
    .parEnable (modeCtrl[0]),
    .strobe    (strobe)
  );

  rxa_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strobe     (strobe),
    .parEven    (modeCtrl[1]),
    .irqMode    (intCtrl[4:3]),
    .parSpecial (intCtrl[2]),
    .dataRead   (dataRead),
    .errClear   (errClear),
    .rearmFirst (rearmFirst),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .errFe      (errFe),
    .errOv      (errOv),
    .errPe      (errPe),
    .rxIrq      (rxIrq)
  );

  assign errStatus = {1'b0, errFe, errOv, errPe, 4'b0000};
endmodule

// File: tb/tb_async_rx_irq.sv
module tb_async_rx_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic bitTick = 1'b0;
  logic dataRead = 1'b0, errClear = 1'b0, rearmFirst = 1'b0;
  logic [1:0] sizeCode = 2'b11, multCode = 2'b01, stopCode = 2'b01, irqMode = 2'b00;
  logic rxEn = 1'b1, parEn = 1'b0, parEven = 1'b0, parSpec = 1'b0;
  logic [7:0] rxCtrl, modeCtrl, intCtrl, rxData, errStatus;
  logic rxReady, rxIrq;
  int tests = 0, fails = 0;

  assign rxCtrl   = {sizeCode, 5'b00000, rxEn};
  assign modeCtrl = {multCode, 2'b00, stopCode, parEven, parEn};
  assign intCtrl  = {3'b000, irqMode, parSpec, 2'b00};

  always #4 clk = ~clk;

  async_rx_irq dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .bitTick(bitTick),
    .rxCtrl(rxCtrl), .modeCtrl(modeCtrl), .intCtrl(intCtrl),
    .dataRead(dataRead), .errClear(errClear), .rearmFirst(rearmFirst),
    .rxData(rxData), .rxReady(rxReady), .errStatus(errStatus), .rxIrq(rxIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic v, input int n);
    rxLine = v;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bitTick = 1'b1;
      @(negedge clk) bitTick = 1'b0;
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) dataRead = 1'b1;
    else if (which == 1) errClear = 1'b1;
    else rearmFirst = 1'b1;
    @(negedge clk);
    dataRead = 1'b0; errClear = 1'b0; rearmFirst = 1'b0;
  endtask

  function automatic int lenOf(input logic [1:0] c);
    return (c == 2'b00) ? 5 : (c == 2'b01) ? 7 : (c == 2'b10) ? 6 : 8;
  endfunction

  function automatic int multVal(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 16 : (c == 2'b10) ? 32 : 64;
  endfunction

  // par: 0 none, 1 even, 2 odd
  task automatic sendFrame(input logic [7:0] val, input int par, input bit badPar,
                           input bit badStop, input int stopTicks, input int idleTicks);
    int len, m;
    logic pb;
    len = lenOf(sizeCode);
    m = multVal(multCode);
    sendBit(1'b0, m);
    for (int i = 0; i < len; i++) sendBit(val[i], m);
    if (par != 0) begin
      pb = 1'b0;
      for (int i = 0; i < len; i++) pb = pb ^ val[i];
      if (par == 2) pb = ~pb;
      if (badPar) pb = ~pb;
      sendBit(pb, m);
    end
    if (badStop) begin
      sendBit(1'b0, m);
      if (stopTicks > m) sendBit(1'b1, stopTicks - m);
    end else begin
      sendBit(1'b1, stopTicks);
    end
    if (idleTicks > 0) sendBit(1'b1, idleTicks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] vals [5];
    logic [7:0] mask;
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h5A; vals[4] = 8'h3C;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset data", rxData, 0);
    chk("R1 reset ready", rxReady, 0);
    chk("R1 reset errors", errStatus, 0);
    chk("R1 reset irq", rxIrq, 0);

    // R2 / R5: length codes x parity modes x patterns at x16
    for (int sc = 0; sc < 4; sc++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int vi = 0; vi < 5; vi++) begin
          sizeCode = 2'(sc);
          parEn = (pm != 0);
          parEven = (pm == 1);
          mask = 8'((1 << lenOf(sizeCode)) - 1);
          sendFrame(vals[vi], pm, 1'b0, 1'b0, 16, 4);
          chk("R2 data", rxData, vals[vi] & mask);
          chk("R2 ready", rxReady, 1);
          chk("R5 good parity no error", errStatus, 0);
          pulse(0);
          chk("R9 read clears ready", rxReady, 0);
        end
      end
    end
    sizeCode = 2'b11; parEn = 1'b0; parEven = 1'b0;

    // R5: bad parity, even and odd
    parEn = 1'b1; parEven = 1'b1;
    sendFrame(8'h37, 1, 1'b1, 1'b0, 16, 4);
    chk("R5 even parity mismatch", errStatus, 8'h10);
    pulse(0); pulse(1);
    parEven = 1'b0;
    sendFrame(8'h37, 2, 1'b1, 1'b0, 16, 4);
    chk("R5 odd parity mismatch", errStatus, 8'h10);
    pulse(0); pulse(1);
    parEn = 1'b0;

    // R14: disabled receiver
    rxEn = 1'b0;
    sendFrame(8'h81, 0, 1'b0, 1'b0, 16, 4);
    chk("R14 disabled no char", rxReady, 0);
    rxEn = 1'b1;

    // R4: short low pulse rejected, then a real frame works
    sendBit(1'b0, 5);
    sendBit(1'b1, 40);
    chk("R4 glitch rejected", rxReady, 0);
    sendFrame(8'hC3, 0, 1'b0, 1'b0, 16, 4);
    chk("R4 frame after glitch", rxData, 8'hC3);
    pulse(0);

    // R3: other multipliers
    for (int mc = 0; mc < 4; mc++) begin
      multCode = 2'(mc);
      parEn = 1'b1; parEven = 1'b1;
      sendFrame(8'h96 ^ 8'(mc), 1, 1'b0, 1'b0, multVal(multCode), 2 * multVal(multCode) + 2);
      chk("R3 multiplier data", rxData, 8'h96 ^ 8'(mc));
      chk("R3 multiplier no error", errStatus, 0);
      pulse(0);
    end
    multCode = 2'b01; parEn = 1'b0;

    // R6: framing error, then back-to-back frames with long stops
    sendFrame(8'h55, 0, 1'b0, 1'b1, 16, 32);
    chk("R6 framing error", errStatus, 8'h40);
    pulse(0); pulse(1);
    stopCode = 2'b10;
    sendFrame(8'h11, 0, 1'b0, 1'b0, 24, 0);
    chk("R6 1.5 stop first", rxData, 8'h11);
    pulse(0);
    sendFrame(8'h22, 0, 1'b0, 1'b0, 24, 4);
    chk("R6 1.5 stop second", rxData, 8'h22);
    chk("R6 1.5 stop clean", errStatus, 0);
    pulse(0);
    stopCode = 2'b11;
    sendFrame(8'h33, 0, 1'b0, 1'b0, 32, 0);
    pulse(0);
    sendFrame(8'h44, 0, 1'b0, 1'b0, 32, 4);
    chk("R6 two stop second", rxData, 8'h44);
    chk("R6 two stop clean", errStatus, 0);
    pulse(0);
    stopCode = 2'b01;

    // R7 / R8: overrun and stickiness
    sendFrame(8'hA1, 0, 1'b0, 1'b0, 16, 0);
    sendFrame(8'hB2, 0, 1'b0, 1'b0, 16, 4);
    chk("R7 overrun flag", errStatus, 8'h20);
    chk("R7 newest data", rxData, 8'hB2);
    pulse(0);
    sendFrame(8'hC4, 0, 1'b0, 1'b0, 16, 4);
    chk("R8 flag sticky", errStatus, 8'h20);
    pulse(0);
    pulse(1);
    chk("R8 clear", errStatus, 0);

    // R10: policy 00 and 11
    irqMode = 2'b00;
    sendFrame(8'h10, 0, 1'b0, 1'b1, 16, 32);
    chk("R10 mode 00 quiet", rxIrq, 0);
    pulse(0); pulse(1);
    irqMode = 2'b11;
    sendFrame(8'h20, 0, 1'b0, 1'b0, 16, 4);
    chk("R10 special-only ignores char", rxIrq, 0);
    pulse(0);
    sendFrame(8'h21, 0, 1'b0, 1'b1, 16, 32);
    chk("R10 special-only framing", rxIrq, 1);
    pulse(0); pulse(1);
    chk("R10 cleared", rxIrq, 0);

    // R11: every character
    irqMode = 2'b10;
    sendFrame(8'h30, 0, 1'b0, 1'b0, 16, 4);
    chk("R11 char irq", rxIrq, 1);
    pulse(0);
    chk("R11 read drops irq", rxIrq, 0);

    // R12: first character
    irqMode = 2'b01;
    sendFrame(8'h40, 0, 1'b0, 1'b0, 16, 4);
    chk("R12 first char irq", rxIrq, 1);
    pulse(0);
    chk("R12 read drops irq", rxIrq, 0);
    sendFrame(8'h41, 0, 1'b0, 1'b0, 16, 4);
    chk("R12 second char quiet", rxIrq, 0);
    pulse(0);
    pulse(2);
    sendFrame(8'h42, 0, 1'b0, 1'b0, 16, 4);
    chk("R12 rearmed irq", rxIrq, 1);
    pulse(0);

    // R13: parity as special condition
    irqMode = 2'b11; parEn = 1'b1; parEven = 1'b1; parSpec = 1'b0;
    sendFrame(8'h5B, 1, 1'b1, 1'b0, 16, 4);
    chk("R13 parity flag recorded", errStatus, 8'h10);
    chk("R13 parity not special", rxIrq, 0);
    pulse(0); pulse(1);
    parSpec = 1'b1;
    sendFrame(8'h5B, 1, 1'b1, 1'b0, 16, 4);
    chk("R13 parity special irq", rxIrq, 1);
    pulse(0); pulse(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule